// File: doc/BRIEF.md
# Page-zero indirect effective-address generator

This block turns an 8-bit operand into a 16-bit effective address for two indirect modes. In both modes the operand points into the lowest 256-byte page of memory, where a two-byte pointer is held. In the pre-indexed mode the X index is added to the operand before the pointer is read. In the post-indexed mode the pointer is read from the operand location and the Y index is added to the pointer afterwards.

A start pulse captures the mode, the operand and both indices. A small sequencer then issues two byte reads on a memory port with a one-cycle return latency: the low pointer byte first, then the high byte. One cycle after the high byte returns, the effective address is registered and a one-cycle done strobe is raised. The effective address output holds its value until the next operation completes.

Top module: `zpi_ea_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0, `rd_en` is 0 and `ea` is 0x0000.
- R2: With `mode`=0 (pre-indexed), the first read address is {0x00, (operand + x) mod 256}; the upper address byte of every read is 0x00.
- R3: With `mode`=0, `ea` equals the 16-bit pointer read, with no index added after the fetch.
- R4: With `mode`=1 (post-indexed), the first read address is {0x00, operand}, and X has no effect.
- R5: With `mode`=1, `ea` equals the pointer plus the zero-extended Y, modulo 65536, so a carry out of the low byte raises the high byte.
- R6: The pointer is little-endian: the byte at the first read address is `ea` bits 7:0 (before any Y add), and the second read address is the first plus one modulo 256, so location 0xFF is followed by 0x00.
- R7: A start accepted at clock edge k gives reads in the cycles after edges k and k+1 only, and `done` high for exactly the cycle after edge k+3.
- R8: A `start` seen while an operation is in progress is ignored: the running result is unchanged and no extra reads or done strobe follow.
- R9: `ea` changes only in a cycle where `done` is 1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation when idle |
| mode | input | 1 | 0 = pre-indexed with X, 1 = post-indexed with Y |
| operand | input | 8 | Page-zero operand field |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default byte width of 8, so the page holds 256 locations and the model memory covers all of it. That width puts both wrap cases within reach: an operand-plus-X sum that overflows past 0xFF, and a pointer stored at 0xFF whose high byte comes from 0x00. It also makes a Y add that carries from the low byte into the high byte easy to provoke with a pointer such as 0x12F0.

// File: rtl/zpi_pkg.sv
package zpi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_SUM  = 2'd3
  } zpi_state_e;

  typedef enum logic {
    MODE_PRE  = 1'b0,
    MODE_POST = 1'b1
  } zpi_mode_e;
endpackage

// File: rtl/zpi_seq_fsm.sv
module zpi_seq_fsm
  import zpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic rd_en,
  output logic phase_hi,
  output logic finish
);
  zpi_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_LO;
      ST_LO:   state_d = ST_HI;
      ST_HI:   state_d = ST_SUM;
      ST_SUM:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept   = (state_q == ST_IDLE) && start;
  assign rd_en    = (state_q == ST_LO) || (state_q == ST_HI);
  assign phase_hi = (state_q == ST_HI);
  assign finish   = (state_q == ST_SUM);
endmodule

// File: rtl/zpi_ptr_locator.sv
module zpi_ptr_locator
  import zpi_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              phase_hi,
  input  logic              mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] post_idx
);
  logic [DATA_W-1:0] loc_q, loc_d;
  logic [DATA_W-1:0] yq_q, yq_d;
  logic [DATA_W-1:0] byte_sel;

  always_comb begin
    loc_d = loc_q;
    yq_d  = yq_q;
    if (accept) begin
      if (zpi_mode_e'(mode) == MODE_PRE) begin
        loc_d = operand + idx_x;
        yq_d  = '0;
      end else begin
        loc_d = operand;
        yq_d  = idx_y;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      yq_q  <= '0;
    end else if (accept) begin
      loc_q <= loc_d;
      yq_q  <= yq_d;
    end
  end

  assign byte_sel = phase_hi ? loc_q + DATA_W'(1) : loc_q;
  assign rd_addr  = {{DATA_W{1'b0}}, byte_sel};
  assign post_idx = yq_q;
endmodule

// File: rtl/zpi_ea_unit.sv
module zpi_ea_unit #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_hi,
  input  logic              finish,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] post_idx,
  output logic [ADDR_W-1:0] ea,
  output logic              done
);
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              done_q;

  always_comb begin
    ea_d = {rd_data, lo_q} + {{DATA_W{1'b0}}, post_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (phase_hi) lo_q <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ea_q <= '0;
    else if (finish) ea_q <= ea_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign ea   = ea_q;
  assign done = done_q;
endmodule

// File: rtl/zpi_ea_gen.sv
module zpi_ea_gen #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ea,
  output logic              done
);
  logic accept, phase_hi, finish;
  logic [DATA_W-1:0] post_idx;

  zpi_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .rd_en(rd_en), .phase_hi(phase_hi), .finish(finish)
  );

  zpi_ptr_locator #(.DATA_W(DATA_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase_hi(phase_hi),
    .mode(mode), .operand(operand), .idx_x(idx_x), .idx_y(idx_y),
    .rd_addr(rd_addr), .post_idx(post_idx)
  );

  zpi_ea_unit #(.DATA_W(DATA_W)) u_ea (
    .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .finish(finish),
    .rd_data(rd_data), .post_idx(post_idx), .ea(ea), .done(done)
  );
endmodule

// File: rtl/zpi_ea_gen_chk.sv
module zpi_ea_gen_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] ea,
  input logic              done
);
  logic [1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reads_q <= '0;
    else if (done) reads_q <= rd_en ? 2'd1 : 2'd0;
    else if (rd_en && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
  end

  p_page_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[ADDR_W-1:DATA_W] == '0);

  p_next_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |->
      rd_addr[DATA_W-1:0] == DATA_W'($past(rd_addr[DATA_W-1:0]) + 1));

  p_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reads_q == 2'd2);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_read_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);

  p_ea_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));
endmodule

bind zpi_ea_gen zpi_ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .ea(ea), .done(done)
);

// File: tb/zpi_ea_gen_bench.sv
`timescale 1ns/1ps
module zpi_ea_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode;
  logic [7:0]  operand, idx_x, idx_y;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] ea;
  logic        done;

  logic [7:0]  mem [256];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  zpi_ea_gen u_zpi_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .operand(operand), .idx_x(idx_x), .idx_y(idx_y),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ea(ea), .done(done)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One operation; hold_start keeps start high with other values during the reads (R8).
  task automatic run_op(input logic m, input logic [7:0] op, input logic [7:0] x,
                        input logic [7:0] y, input bit hold_start, input string tag);
    logic [7:0]  loc;
    logic [15:0] ptr, exp_ea, prev_ea;
    loc    = (m == 1'b0) ? 8'(op + x) : op;
    ptr    = {mem[8'(loc + 8'd1)], mem[loc]};
    exp_ea = (m == 1'b0) ? ptr : 16'(ptr + {8'h00, y});
    @(negedge clk);
    start = 1; mode = m; operand = op; idx_x = x; idx_y = y;
    @(negedge clk);
    if (hold_start) begin mode = ~m; operand = ~op; idx_x = ~x; idx_y = ~y; end
    else start = 0;
    prev_ea = ea;
    check({tag, " R7 read1 en"}, rd_en, 1);
    check({tag, " R2/R4 read1 addr"}, rd_addr, {8'h00, loc});
    check({tag, " R7 no early done"}, done, 0);
    @(negedge clk);
    start = 0;
    check({tag, " R7 read2 en"}, rd_en, 1);
    check({tag, " R6 read2 addr"}, rd_addr, {8'h00, 8'(loc + 8'd1)});
    check({tag, " R9 ea held"}, ea, prev_ea);
    @(negedge clk);
    check({tag, " R7 idle before done"}, {rd_en, done}, 0);
    @(negedge clk);
    check({tag, " R7 done"}, done, 1);
    check({tag, " R3/R5 ea"}, ea, exp_ea);
    check({tag, " R7 no third read"}, rd_en, 0);
    @(negedge clk);
    check({tag, " R7 done one cycle"}, done, 0);
    check({tag, " R8 no extra read"}, rd_en, 0);
    check({tag, " R9 ea kept"}, ea, exp_ea);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; mode = 0; operand = 0; idx_x = 0; idx_y = 0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 rd_en in reset", rd_en, 0);
    check("R1 ea in reset", ea, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {15'd0, rd_en, done, ea}, 0);
  endtask

  task automatic t_pre_basic();
    mem[8'h25] = 8'h34; mem[8'h26] = 8'h12;
    run_op(1'b0, 8'h20, 8'h05, 8'hAA, 0, "R2 R3 pre basic");
  endtask

  task automatic t_pre_wrap_sum();
    mem[8'h10] = 8'hCD; mem[8'h11] = 8'hAB;
    run_op(1'b0, 8'hF0, 8'h20, 8'h77, 0, "R2 pre sum wraps");
  endtask

  task automatic t_pre_ptr_at_ff();
    mem[8'hFF] = 8'h78; mem[8'h00] = 8'h56;
    run_op(1'b0, 8'hFE, 8'h01, 8'h00, 0, "R6 pre ptr at FF");
  endtask

  task automatic t_post_basic();
    mem[8'h40] = 8'h00; mem[8'h41] = 8'h30;
    run_op(1'b1, 8'h40, 8'h99, 8'h15, 0, "R4 R5 post basic");
  endtask

  task automatic t_post_carry();
    mem[8'h80] = 8'hF0; mem[8'h81] = 8'h12;
    run_op(1'b1, 8'h80, 8'h03, 8'h20, 0, "R5 post carry");
  endtask

  task automatic t_post_top();
    mem[8'hC0] = 8'hFF; mem[8'hC1] = 8'hFF;
    run_op(1'b1, 8'hC0, 8'h00, 8'h02, 0, "R5 post 16b wrap");
  endtask

  task automatic t_post_ptr_at_ff();
    mem[8'hFF] = 8'h10; mem[8'h00] = 8'h9A;
    run_op(1'b1, 8'hFF, 8'h00, 8'hFF, 0, "R6 post ptr at FF");
  endtask

  task automatic t_busy_start();
    mem[8'h33] = 8'h11; mem[8'h34] = 8'h22;
    mem[8'hCC] = 8'h55; mem[8'hCD] = 8'h66;
    run_op(1'b1, 8'h33, 8'h00, 8'h01, 1, "R8 busy start");
  endtask

  task automatic t_back_to_back();
    mem[8'h50] = 8'hEE; mem[8'h51] = 8'hDD;
    run_op(1'b0, 8'h4F, 8'h01, 8'h00, 0, "R9 repeat op1");
    mem[8'h60] = 8'h01; mem[8'h61] = 8'h02;
    run_op(1'b1, 8'h60, 8'h00, 8'h00, 0, "R9 repeat op2");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    t_reset();
    t_pre_basic();
    t_pre_wrap_sum();
    t_pre_ptr_at_ff();
    t_post_basic();
    t_post_carry();
    t_post_top();
    t_post_ptr_at_ff();
    t_busy_start();
    t_back_to_back();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end
endmodule